// File: doc/BRIEF.md
# Active Video Edge Softener

This block sits in the luma path of a standard-definition video encoder. It stops a full-scale step from appearing at either end of the active part of a line, because such a step rings in the analog filters that come after it. The block scales the three pixels at the start and the three pixels at the end of each active run by a fixed ramp of weights. Every other pixel leaves the block unchanged. With the enable clear, the block is a plain delay.

Scaling applies only to the part of the sample above black level, so blanking stays where it is. For example, a jump from black to peak white becomes about one eighth of that height on the first pixel. The block has to know where the line ends before it can reach the last pixels, so it holds samples in a short delay line. It finds the end of the run from the active flag a few samples ahead. Luma and the active flag both come out four clocks after they go in.

Top module: `edge_softener`

## Requirements
- R1: `y_out` and `act_out` present the sample and flag that were on `y_in` and `act_in` exactly 4 clock cycles earlier.
- R2: `en` is sampled when a pixel leaves the delay line, 3 cycles after the pixel was presented. When it is 0, `y_out` equals the delayed `y_in` exactly.
- R3: With `en` set, active pixels at positions 0, 1 and 2 of a run (position 0 is the first cycle `act_in` is 1) are scaled by 1/8, 1/2 and 7/8 in that order.
- R4: With `en` set, the last, second-to-last and third-to-last active pixels of a run are scaled by 1/8, 1/2 and 7/8. The run ends on the first cycle `act_in` is 0.
- R5: Active pixels that are neither among the first three nor among the last three of their run, and all samples with `act_in` 0, pass unchanged.
- R6: Scaling acts on the excursion e = y − black. The result is black + round(w·e) with halves rounded up: (e+4)>>3 for 1/8, (e+1)>>1 for 1/2, and (7e+4)>>3 for 7/8.
- R7: The black level is 16 for 8-bit luma. A sample at or below black passes unchanged. A scaled output is never above its input and never below black.
- R8: In a run shorter than six pixels, a pixel in the first three positions takes its start weight rather than its end weight, and no pixel is scaled twice. A 1-pixel run gets 1/8. A 4-pixel run gets 1/8, 1/2, 7/8, 1/8. A 5-pixel run gets 1/8, 1/2, 7/8, 1/2, 1/8.
- R9: While `rst` is high, `y_out` and `act_out` are 0 from the first clock edge onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Edge softening enable |
| act_in | input | 1 | Active-video flag for the incoming sample |
| y_in | input | DATA_W | Incoming luma sample |
| act_out | output | 1 | Active flag, delayed by 4 cycles |
| y_out | output | DATA_W | Luma sample, delayed by 4 cycles, edge-scaled when enabled |

## Verification
Full-scale step lines of every length from 1 to 12 separate the start ramp, the end ramp and the short-line priority, because each length gives its own sequence of weights. A sweep of all 256 input levels on 7-pixel lines tries every weight against every excursion. This exposes rounding errors and mistakes at or below black level. Lines with the enable clear tell a true bypass from one that still scales. A long graded line shows that pixels in the middle of a run are left alone and that the gap samples between runs pass untouched.

// File: rtl/edge_soft_pkg.sv
package edge_soft_pkg;
  localparam int RAMP = 3;

  typedef enum logic [1:0] {
    W_NONE   = 2'd0,
    W_EIGHTH = 2'd1,
    W_HALF   = 2'd2,
    W_SEVEN8 = 2'd3
  } weight_e;

  // ramp slot 0 is outermost pixel of the run, slot 2 innermost
  function automatic weight_e ramp_weight(input int unsigned slot);
    case (slot)
      0:       ramp_weight = W_EIGHTH;
      1:       ramp_weight = W_HALF;
      default: ramp_weight = W_SEVEN8;
    endcase
  endfunction
endpackage

// File: rtl/edge_tap_line.sv
module edge_tap_line #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] y_in,
  input  logic              act_in,
  output logic [DATA_W-1:0] y_tap   [DEPTH],
  output logic              act_tap [DEPTH]
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          y_tap[g]   <= '0;
          act_tap[g] <= 1'b0;
        end else begin
          y_tap[g]   <= y_in;
          act_tap[g] <= act_in;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) begin
          y_tap[g]   <= '0;
          act_tap[g] <= 1'b0;
        end else begin
          y_tap[g]   <= y_tap[g-1];
          act_tap[g] <= act_tap[g-1];
        end
      end
    end
  end
endmodule

// File: rtl/edge_weight_sel.sv
module edge_weight_sel
  import edge_soft_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            tail_act,
  input  logic [RAMP-1:0] look_act,
  output weight_e         code
);
  localparam int CNT_W = $clog2(RAMP + 1);
  localparam logic [CNT_W-1:0] RAMP_C = CNT_W'(RAMP);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] end_idx;
  logic             start_hit;
  logic             end_hit;
  logic             run;

  // count active pixels of the current run that already left the tail
  always_ff @(posedge clk) begin
    if (rst || !tail_act) cnt <= '0;
    else if (cnt < RAMP_C) cnt <= cnt + 1'b1;
  end

  assign start_hit = tail_act && (cnt < RAMP_C);

  always_comb begin
    end_hit = 1'b0;
    end_idx = '0;
    run     = 1'b1;
    for (int k = 0; k < RAMP; k++) begin
      if (run && !look_act[k] && !end_hit) begin
        end_hit = 1'b1;
        end_idx = CNT_W'(k);
      end
      run = run & look_act[k];
    end
  end

  always_comb begin
    if (!tail_act)      code = W_NONE;
    else if (start_hit) code = ramp_weight(int'(cnt));      // start has priority (R8)
    else if (end_hit)   code = ramp_weight(int'(end_idx));
    else                code = W_NONE;
  end

  assert_idle_pass_R5: assert property (@(posedge clk) disable iff (rst)
    !tail_act |-> code == W_NONE);

  assert_start_first_R8: assert property (@(posedge clk) disable iff (rst)
    (tail_act && !$past(tail_act)) |-> code == W_EIGHTH);
endmodule

// File: rtl/edge_scaler.sv
module edge_scaler
  import edge_soft_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] BLACK = 8'd16
) (
  input  logic [DATA_W-1:0] y,
  input  weight_e           code,
  output logic [DATA_W-1:0] y_scaled
);
  logic              above;
  logic [DATA_W:0]   exc;
  logic [DATA_W:0]   s;

  assign above = y > BLACK;
  assign exc   = above ? {1'b0, y - BLACK} : '0;

  always_comb begin
    case (code)
      W_EIGHTH: s = (exc + (DATA_W+1)'(4)) >> 3;
      W_HALF:   s = (exc + (DATA_W+1)'(1)) >> 1;
      W_SEVEN8: s = exc - ((exc + (DATA_W+1)'(3)) >> 3);
      default:  s = exc;
    endcase
  end

  assign y_scaled = above ? BLACK + s[DATA_W-1:0] : y;

  always_comb begin
    assert_scale_bound_R6: assert (s <= exc);
  end
endmodule

// File: rtl/edge_softener.sv
module edge_softener
  import edge_soft_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] BLACK = DATA_W'(16) << (DATA_W - 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              act_in,
  input  logic [DATA_W-1:0] y_in,
  output logic              act_out,
  output logic [DATA_W-1:0] y_out
);
  localparam int DEPTH = RAMP;
  localparam int LAT   = DEPTH + 1;

  logic [DATA_W-1:0] y_tap   [DEPTH];
  logic              act_tap [DEPTH];
  logic [RAMP-1:0]   look_act;
  weight_e           code;
  logic [DATA_W-1:0] y_scaled;

  edge_tap_line #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_taps (
    .clk(clk), .rst(rst), .y_in(y_in), .act_in(act_in),
    .y_tap(y_tap), .act_tap(act_tap)
  );

  // look_act[k]: flag of the sample k+1 places behind the tail
  for (genvar k = 0; k < RAMP; k++) begin : g_look
    if (k < DEPTH - 1) begin : g_tap
      assign look_act[k] = act_tap[DEPTH-2-k];
    end else begin : g_in
      assign look_act[k] = act_in;
    end
  end

  edge_weight_sel u_sel (
    .clk(clk), .rst(rst), .tail_act(act_tap[DEPTH-1]),
    .look_act(look_act), .code(code)
  );

  edge_scaler #(.DATA_W(DATA_W), .BLACK(BLACK)) u_scale (
    .y(y_tap[DEPTH-1]), .code(code), .y_scaled(y_scaled)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      y_out   <= '0;
      act_out <= 1'b0;
    end else begin
      y_out   <= en ? y_scaled : y_tap[DEPTH-1];
      act_out <= act_tap[DEPTH-1];
    end
  end

  // cycles since reset, for assertion windows only
  logic [2:0] fill;
  always_ff @(posedge clk) begin
    if (rst) fill <= '0;
    else if (fill < 3'(LAT)) fill <= fill + 1'b1;
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    (fill >= 3'(LAT)) |-> act_out == $past(act_in, 4));

  assert_bypass_R2: assert property (@(posedge clk) disable iff (rst)
    (fill >= 3'(LAT) && !$past(en)) |-> y_out == $past(y_in, 4));

  assert_no_boost_R7: assert property (@(posedge clk) disable iff (rst)
    (fill >= 3'(LAT)) |-> y_out <= $past(y_in, 4));

  assert_floor_R7: assert property (@(posedge clk) disable iff (rst)
    (fill >= 3'(LAT) && $past(y_in, 4) > BLACK) |-> y_out >= BLACK);
endmodule

// File: tb/edge_softener_tb.sv
module edge_softener_tb_top;
  localparam int MAXN = 4096;
  localparam int BLK  = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       act_in = 1'b0;
  logic [7:0] y_in = '0;
  logic       act_out;
  logic [7:0] y_out;

  int y_s [MAXN];
  bit a_s [MAXN];
  bit e_s [MAXN];
  int n = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  edge_softener dut_i (
    .clk(clk), .rst(rst), .en(en), .act_in(act_in),
    .y_in(y_in), .act_out(act_out), .y_out(y_out)
  );

  task automatic push(input int y, input bit a, input bit e);
    y_s[n] = y; a_s[n] = a; e_s[n] = e; n++;
  endtask

  task automatic line(input int len, input int y, input bit e, input int gap, input int gy);
    for (int i = 0; i < len; i++) push(y, 1'b1, e);
    for (int i = 0; i < gap; i++) push(gy, 1'b0, e);
  endtask

  function automatic int scale(input int y, input int slot);
    int e;
    if (y <= BLK) return y;
    e = y - BLK;
    case (slot)
      0: return BLK + ((e + 4) >> 3);
      1: return BLK + ((e + 1) >> 1);
      default: return BLK + ((7 * e + 4) >> 3);
    endcase
  endfunction

  // expected value and requirement tag for sample i
  function automatic int expv(input int i, output string tag);
    int p, q, len;
    p = 0; q = 0;
    if (!a_s[i]) begin tag = "R5"; return y_s[i]; end
    if (!e_s[i+3]) begin tag = "R2"; return y_s[i]; end
    while (i - p - 1 >= 0 && a_s[i-p-1]) p++;
    while (a_s[i+q+1]) q++;
    len = p + q + 1;
    if (p >= 3 && q >= 3) begin tag = "R5"; return y_s[i]; end
    if (y_s[i] <= BLK) tag = "R7";
    else if (len < 6) tag = "R8";
    else if (p < 3) tag = "R3,R6";
    else tag = "R4,R6";
    if (p < 3) return scale(y_s[i], p);
    return scale(y_s[i], q);
  endfunction

  initial begin
    int ev;
    string tag;
    // stream
    for (int i = 0; i < 6; i++) push(0, 0, 1);
    for (int len = 1; len <= 12; len++) line(len, 235, 1'b1, 3, BLK);
    for (int v = 0; v < 256; v++) line(7, v, 1'b1, 2, v ^ 8'h5a);
    for (int len = 1; len <= 8; len++) line(len, 200, 1'b0, 3, BLK);
    line(4, 235, 1'b1, 3, BLK);
    for (int i = 0; i < 40; i++) push(20 + i * 5, 1'b1, 1'b1);
    for (int i = 0; i < 12; i++) push(0, 1'b0, 1'b0);

    // reset state (R9)
    repeat (3) @(negedge clk);
    checks++;
    if (y_out !== 8'd0 || act_out !== 1'b0) begin
      fails++;
      $display("FAIL R9 reset: y_out=%0d act_out=%0b expected 0/0", y_out, act_out);
    end

    for (int j = 0; j < n - 4; j++) begin
      if (j >= 4) begin
        checks++;
        if (act_out !== a_s[j-4]) begin
          fails++;
          $display("FAIL R1 sample %0d: act_out=%0b expected %0b", j - 4, act_out, a_s[j-4]);
        end
        ev = expv(j - 4, tag);
        checks++;
        if (int'(y_out) != ev) begin
          fails++;
          $display("FAIL %s sample %0d: y_out=%0d expected %0d", tag, j - 4, y_out, ev);
        end
      end
      rst    = 1'b0;
      y_in   = 8'(y_s[j]);
      act_in = a_s[j];
      en     = e_s[j];
      @(negedge clk);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule